// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry Controller

This block sits next to the command scheduler of an SDRAM controller. It moves the memory into self refresh when the device has been idle long enough, and brings it back out when a new access arrives. When self refresh is requested and the idle timeout has run out, it issues a precharge-all command and then a self-refresh command, and it drives the clock-enable low. If an access shows up between those two commands, the self-refresh command is replaced by an auto-refresh command and the memory stays awake.

When an access arrives while the device is in self refresh, the block first keeps the clock-enable low for a minimum residency. That minimum is taken from the timing input that belongs to the memory type in use. The block then issues an exit command and holds the command slot at NOP for a configurable settling delay.

The block also keeps the memory's extended mode register (partial-array, drive-strength and temperature fields) in step with the configuration. Once initialisation is complete, any change to those fields leads to a register write. In the dedicated-bus mode the write goes into the self-refresh entry sequence. In the shared-bus mode it goes into a refresh slot while an access is pending.

While the block is driving commands or holding the memory in self refresh, a busy output tells the normal scheduler to stay off the command bus.

Top module: `srf_lp_ctrl`

## Requirements
- R1: During and directly after reset, `cke` is 1, `cmd_vld` is 0, `cmd` is 0 (NOP) and `busy` is 0.
- R2: Commands are only issued when `lp_mode` is 2'b01. With any other `lp_mode` value, `cmd_vld` stays 0 and `cke` stays 1 however long the device is idle.
- R3: The idle limit L is set by `tmo_code`: 2'b00 and 2'b11 give L = 0, 2'b01 gives L = 64 and 2'b10 gives L = 128. Each `acc_done` pulse and each cycle with `dev_sel` high restarts the idle count. With `dev_sel` low, the precharge-all strobe appears in the cycle that follows the (L+1)-th rising edge after the edge that captured the last `acc_done`.
- R4: Command codes on `cmd` are NOP 0, PRECHARGE_ALL 1, SELF_REFRESH 2, AUTO_REFRESH 3, LOAD_EMR 4 and SR_EXIT 5. Each command is a one-cycle strobe with `cmd_vld` high. PRECHARGE_ALL is followed in the very next cycle by SELF_REFRESH, unless R5 or R10 applies.
- R5: If `dev_sel` is high during the PRECHARGE_ALL cycle (or during the LOAD_EMR cycle that follows it), the next command is AUTO_REFRESH instead of SELF_REFRESH. `cke` stays 1, and `busy` drops in the cycle after that command.
- R6: `cke` goes low in the SELF_REFRESH strobe cycle and stays low until the SR_EXIT strobe cycle. `cke` is 1 in every other cycle.
- R7: The minimum residency M is `t_ras` when `mem_kind` is 2'b00, `t_rfc` when it is 2'b01, and `t_cke` when it is 2'b10 or 2'b11. An access that is pending from entry onward is held off until `cke` has been low for exactly M+1 cycles (for M ≥ 1). An access that arrives after that gets SR_EXIT in the next cycle.
- R8: After the SR_EXIT strobe, during which `cke` is 1, the block holds `busy` high with `cmd_vld` low for exactly `exit_dly` cycles. `busy` is low after that.
- R9: `busy` is high in every cycle in which a command sequence runs or `cke` is low, and low when the block is idle.
- R10: In the dedicated-bus mode (`emr_shared` 0), once `init_done` is 1, a change of `emr_fields` puts one LOAD_EMR strobe between PRECHARGE_ALL and SELF_REFRESH. During that strobe, `emr_data` equals the new field value. With the fields unchanged, no LOAD_EMR is issued.
- R11: In the shared-bus mode (`emr_shared` 1), a pending field change is written by a LOAD_EMR strobe in the cycle after a `ref_slot` cycle in which the block is idle and `dev_sel` is high. The self-refresh entry sequence carries no LOAD_EMR in this mode.
- R12: While `init_done` is 0, field changes cause no LOAD_EMR strobe.
- R13: `cmd` reads 0 in every cycle in which `cmd_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_mode | input | 2 | Low-power request; 2'b01 enables self refresh |
| tmo_code | input | 2 | Idle timeout selector |
| mem_kind | input | 2 | Memory type selecting the residency source |
| t_ras | input | CNT_W | Residency for low-power SDR |
| t_rfc | input | CNT_W | Residency for low-power DDR1 |
| t_cke | input | CNT_W | Residency for DDR2 |
| exit_dly | input | CNT_W | NOP cycles after SR_EXIT |
| emr_shared | input | 1 | 1 = bus shared, mode-register writes go to refresh slots |
| init_done | input | 1 | Memory initialisation finished |
| emr_fields | input | EMR_W | Requested partial-array, drive and temperature fields |
| dev_sel | input | 1 | Device selected / access pending |
| acc_done | input | 1 | Pulse on access completion |
| ref_slot | input | 1 | Scheduler is issuing a refresh this cycle |
| cmd_vld | output | 1 | Command strobe |
| cmd | output | 3 | Encoded command |
| cke | output | 1 | Clock-enable to the memory |
| busy | output | 1 | Blocks the normal scheduler |
| emr_data | output | EMR_W | Field value carried by LOAD_EMR |

## Verification
The bench builds the block with its default parameters: 8-bit timing counters, 7-bit mode fields, and idle limits of 64 and 128 cycles. This lets it sweep all four timeout codes at their true lengths and measure each one to the exact cycle. It drives the residency and exit-delay inputs with small values, so every memory type can be crossed with every exit delay from 0 to 3 in a short run. Each residency and settling window is counted cycle by cycle. The same small configuration makes it cheap to walk the auto-refresh substitution and the mode-register update in both bus modes, both before and after initialisation.

// File: rtl/srf_pkg.sv
// Package: command codes and controller states shared by the self-refresh
// controller and its checker. Assumes a 3-bit command bus toward the PHY.
package srf_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PALL = 3'd1,
        CMD_SREF = 3'd2,
        CMD_AREF = 3'd3,
        CMD_LEMR = 3'd4,
        CMD_SRX  = 3'd5
    } srf_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_PALL  = 4'd1,
        ST_EMRW  = 4'd2,
        ST_SREF  = 4'd3,
        ST_HOLD  = 4'd4,
        ST_AREF  = 4'd5,
        ST_SRX   = 4'd6,
        ST_XWAIT = 4'd7,
        ST_EMRS  = 4'd8
    } srf_st_e;

    localparam logic [1:0] LP_SELF_REFRESH = 2'b01;

endpackage

// File: rtl/srf_idle_timer.sv
// Idle timer: counts cycles since the last access completion while the
// device is deselected, and flags expiry against the limit picked by the
// timeout code. Assumes LONG_IDLE >= SHORT_IDLE.
module srf_idle_timer #(
    parameter int SHORT_IDLE = 64,
    parameter int LONG_IDLE  = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_on,
    input  logic       dev_sel,
    input  logic       acc_done,
    input  logic [1:0] tmo_code,
    output logic       expired
);
    localparam int CW = $clog2(LONG_IDLE + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    // Limit decode; reserved code behaves like immediate entry.
    always_comb begin
        case (tmo_code)
            2'b01:   limit = CW'(SHORT_IDLE);
            2'b10:   limit = CW'(LONG_IDLE);
            default: limit = '0;
        endcase
    end

    // Saturating idle counter, cleared by activity or a disabled mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (dev_sel || acc_done || !lp_on)
            cnt_q <= '0;
        else if (cnt_q != CW'(LONG_IDLE))
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = lp_on && !dev_sel && !acc_done && (cnt_q >= limit);

endmodule

// File: rtl/srf_down_cnt.sv
// Loadable down counter that stops at zero; used for the self-refresh
// residency window and for the post-exit settling window.
module srf_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    // Load has priority over decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/srf_emr_track.sv
// Extended-mode-register tracker: keeps a copy of the last value written
// to the memory and flags a pending write when the configured fields
// differ from it. Before initialisation the copy follows the fields.
module srf_emr_track #(
    parameter int EMR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_done,
    input  logic [EMR_W-1:0] fields,
    input  logic             capture,
    output logic             pending,
    output logic [EMR_W-1:0] written
);
    // Shadow copy of the fields last sent to the memory.
    always_ff @(posedge clk) begin
        if (!rst_n)
            written <= '0;
        else if (!init_done || capture)
            written <= fields;
    end

    assign pending = init_done && (fields != written);

endmodule

// File: rtl/srf_lp_ctrl.sv
// Self-refresh entry/exit controller. Sequences precharge-all, optional
// mode-register write and self-refresh (or auto-refresh on a late access),
// enforces a per-memory-type residency and an exit settling delay.
// Assumes configuration inputs are static while a sequence runs.
module srf_lp_ctrl
    import srf_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int EMR_W      = 7,
    parameter int SHORT_IDLE = 64,
    parameter int LONG_IDLE  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       lp_mode,
    input  logic [1:0]       tmo_code,
    input  logic [1:0]       mem_kind,
    input  logic [CNT_W-1:0] t_ras,
    input  logic [CNT_W-1:0] t_rfc,
    input  logic [CNT_W-1:0] t_cke,
    input  logic [CNT_W-1:0] exit_dly,
    input  logic             emr_shared,
    input  logic             init_done,
    input  logic [EMR_W-1:0] emr_fields,
    input  logic             dev_sel,
    input  logic             acc_done,
    input  logic             ref_slot,
    output logic             cmd_vld,
    output logic [2:0]       cmd,
    output logic             cke,
    output logic             busy,
    output logic [EMR_W-1:0] emr_data
);
    srf_st_e          st_q, st_d;
    srf_cmd_e         cmd_e;
    logic             lp_on;
    logic             idle_exp;
    logic             emr_pend;
    logic             hit_q;
    logic [CNT_W-1:0] res_min;
    logic [CNT_W-1:0] res_cnt;
    logic [CNT_W-1:0] x_cnt;
    logic             res_load, res_dec;
    logic             x_load, x_dec;
    logic             emr_cap;

    assign lp_on = (lp_mode == LP_SELF_REFRESH);

    srf_idle_timer #(
        .SHORT_IDLE (SHORT_IDLE),
        .LONG_IDLE  (LONG_IDLE)
    ) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .lp_on    (lp_on),
        .dev_sel  (dev_sel),
        .acc_done (acc_done),
        .tmo_code (tmo_code),
        .expired  (idle_exp)
    );

    srf_emr_track #(
        .EMR_W (EMR_W)
    ) u_emr (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (init_done),
        .fields    (emr_fields),
        .capture   (emr_cap),
        .pending   (emr_pend),
        .written   (emr_data)
    );

    // Residency source selected by memory type.
    always_comb begin
        case (mem_kind)
            2'b00:   res_min = t_ras;
            2'b01:   res_min = t_rfc;
            default: res_min = t_cke;
        endcase
    end

    srf_down_cnt #(
        .W (CNT_W)
    ) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (res_load),
        .load_val (res_min),
        .dec      (res_dec),
        .cnt      (res_cnt)
    );

    srf_down_cnt #(
        .W (CNT_W)
    ) u_exit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (x_load),
        .load_val (exit_dly),
        .dec      (x_dec),
        .cnt      (x_cnt)
    );

    // Next-state decision for the entry/exit sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (emr_shared && emr_pend && ref_slot && dev_sel)
                    st_d = ST_EMRS;
                else if (idle_exp)
                    st_d = ST_PALL;
            end
            ST_PALL: begin
                if (!emr_shared && emr_pend)
                    st_d = ST_EMRW;
                else if (dev_sel)
                    st_d = ST_AREF;
                else
                    st_d = ST_SREF;
            end
            ST_EMRW:  st_d = (dev_sel || hit_q) ? ST_AREF : ST_SREF;
            ST_SREF:  st_d = ST_HOLD;
            ST_HOLD:  if (dev_sel && res_cnt == '0) st_d = ST_SRX;
            ST_AREF:  st_d = ST_IDLE;
            ST_EMRS:  st_d = ST_IDLE;
            ST_SRX:   st_d = (x_cnt == '0) ? ST_IDLE : ST_XWAIT;
            ST_XWAIT: if (x_cnt <= CNT_W'(1)) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Counter and shadow controls derived from the transition.
    assign res_load = (st_d == ST_SREF) && (st_q != ST_SREF);
    assign res_dec  = (st_q == ST_SREF) || (st_q == ST_HOLD);
    assign x_load   = (st_d == ST_SRX) && (st_q != ST_SRX);
    assign x_dec    = (st_q == ST_XWAIT);
    assign emr_cap  = ((st_d == ST_EMRW) && (st_q != ST_EMRW)) ||
                      ((st_d == ST_EMRS) && (st_q != ST_EMRS));

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Remembers an access seen during precharge-all for the next decision.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hit_q <= 1'b0;
        else
            hit_q <= (st_q == ST_PALL) && dev_sel;
    end

    // Command decode from the current state.
    always_comb begin
        case (st_q)
            ST_PALL:          cmd_e = CMD_PALL;
            ST_EMRW, ST_EMRS: cmd_e = CMD_LEMR;
            ST_SREF:          cmd_e = CMD_SREF;
            ST_AREF:          cmd_e = CMD_AREF;
            ST_SRX:           cmd_e = CMD_SRX;
            default:          cmd_e = CMD_NOP;
        endcase
    end

    assign cmd     = cmd_e;
    assign cmd_vld = (cmd_e != CMD_NOP);
    assign cke     = !((st_q == ST_SREF) || (st_q == ST_HOLD));
    assign busy    = (st_q != ST_IDLE);

endmodule

// File: rtl/srf_lp_ctrl_chk.sv
// Checker: temporal properties of the self-refresh controller ports,
// bound into every instance of the top module.
module srf_lp_ctrl_chk
    import srf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       lp_mode,
    input logic             dev_sel,
    input logic [1:0]       mem_kind,
    input logic [CNT_W-1:0] t_ras,
    input logic [CNT_W-1:0] t_rfc,
    input logic [CNT_W-1:0] t_cke,
    input logic             cmd_vld,
    input logic [2:0]       cmd,
    input logic             cke,
    input logic             busy
);
    logic [CNT_W:0]   low_cnt;
    logic [CNT_W-1:0] sel_min;

    // Expected residency for the configured memory type.
    always_comb begin
        case (mem_kind)
            2'b00:   sel_min = t_ras;
            2'b01:   sel_min = t_rfc;
            default: sel_min = t_cke;
        endcase
    end

    // Counts consecutive cycles with the clock-enable low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (cke)
            low_cnt <= '0;
        else if (low_cnt != '1)
            low_cnt <= low_cnt + 1'b1;
    end

    AST_PALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == CMD_PALL) |-> ($past(lp_mode) == LP_SELF_REFRESH && !$past(dev_sel))); // R2
    AST_PALL_FOLLOWUP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == CMD_PALL) |=> (cmd_vld && (cmd == CMD_LEMR || cmd == CMD_SREF || cmd == CMD_AREF))); // R4
    AST_AREF_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == CMD_AREF) |-> (cke && $past(cmd_vld))); // R5
    AST_CKE_FALL_ON_SREF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (cmd_vld && cmd == CMD_SREF)); // R6
    AST_RESIDENCY_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == CMD_SRX) |-> (low_cnt > {1'b0, sel_min})); // R7
    AST_EXIT_RAISES_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd == CMD_SRX) |-> (cke && !$past(cke))); // R8
    AST_LOW_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> busy); // R9

endmodule

bind srf_lp_ctrl srf_lp_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lp_mode  (lp_mode),
    .dev_sel  (dev_sel),
    .mem_kind (mem_kind),
    .t_ras    (t_ras),
    .t_rfc    (t_rfc),
    .t_cke    (t_cke),
    .cmd_vld  (cmd_vld),
    .cmd      (cmd),
    .cke      (cke),
    .busy     (busy)
);

// File: tb/srf_lp_ctrl_tb.sv
// Self-checking bench for the self-refresh controller: sweeps timeout
// codes, memory types and exit delays with small timing inputs.
module srf_lp_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int C_NOP = 0, C_PALL = 1, C_SREF = 2, C_AREF = 3, C_LEMR = 4, C_SRX = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] lp_mode, tmo_code, mem_kind;
    logic [7:0] t_ras, t_rfc, t_cke, exit_dly;
    logic       emr_shared, init_done, dev_sel, acc_done, ref_slot;
    logic [6:0] emr_fields;
    logic       cmd_vld, cke, busy;
    logic [2:0] cmd;
    logic [6:0] emr_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    srf_lp_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .tmo_code(tmo_code),
        .mem_kind(mem_kind), .t_ras(t_ras), .t_rfc(t_rfc), .t_cke(t_cke),
        .exit_dly(exit_dly), .emr_shared(emr_shared), .init_done(init_done),
        .emr_fields(emr_fields), .dev_sel(dev_sel), .acc_done(acc_done),
        .ref_slot(ref_slot), .cmd_vld(cmd_vld), .cmd(cmd), .cke(cke),
        .busy(busy), .emr_data(emr_data)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Caller has just driven acc_done=1 with dev_sel=0; counts negedges
    // until the precharge-all strobe shows.
    task automatic wait_pall(output int k);
        k = 0;
        for (int i = 0; i < 400; i++) begin
            tick();
            k++;
            acc_done = 1'b0;
            if (cmd_vld && cmd == 3'(C_PALL)) break;
        end
    endtask

    task automatic start_idle(output int k);
        dev_sel  = 1'b0;
        acc_done = 1'b1;
        wait_pall(k);
    endtask

    task automatic leave_sr();
        dev_sel = 1'b1;
        for (int i = 0; i < 600; i++) begin
            tick();
            if (!busy) break;
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k, n, d, bad, m;
        rst_n = 1'b0; lp_mode = 2'b01; tmo_code = 2'b00; mem_kind = 2'b00;
        t_ras = 8'd5; t_rfc = 8'd9; t_cke = 8'd3; exit_dly = 8'd0;
        emr_shared = 1'b0; init_done = 1'b0; dev_sel = 1'b1; acc_done = 1'b0;
        ref_slot = 1'b0; emr_fields = 7'h00;
        repeat (3) tick();
        // R1 during reset
        chk(cke && !cmd_vld && cmd == 3'd0 && !busy, "R1 reset outputs", {cmd_vld, cke, busy}, 3'b010);
        rst_n = 1'b1;
        tick();
        chk(cke && !cmd_vld && cmd == 3'd0 && !busy, "R1 after release", {cmd_vld, cke, busy}, 3'b010);

        // R2: non-self-refresh modes never issue commands
        for (int lp = 0; lp < 4; lp++) begin
            if (lp == 1) continue;
            lp_mode = 2'(lp); dev_sel = 1'b0; acc_done = 1'b1;
            bad = 0;
            for (int i = 0; i < 140; i++) begin
                tick();
                acc_done = 1'b0;
                if (cmd_vld || !cke) bad++;
            end
            chk(bad == 0, "R2 gated mode", bad, 0);
            dev_sel = 1'b1; tick();
            lp_mode = 2'b01; tick();
        end

        // R3 sweep over timeout codes; PRE seen L+2 negedges after driving
        for (int c = 0; c < 4; c++) begin
            tmo_code = 2'(c);
            m = (c == 1) ? 64 : (c == 2) ? 128 : 0;
            start_idle(k);
            chk(k == m + 2, "R3 timeout code", k, m + 2);
            tick();
            chk(cmd_vld && cmd == 3'(C_SREF), "R4 SREF follows PRE", cmd, C_SREF);
            chk(!cke, "R6 cke low at SREF", cke, 0);
            leave_sr();
        end

        // R3 restart of the idle count by a later completion
        tmo_code = 2'b01;
        dev_sel = 1'b0; acc_done = 1'b1;
        tick(); acc_done = 1'b0;
        bad = 0;
        for (int i = 0; i < 29; i++) begin
            tick();
            if (cmd_vld) bad++;
        end
        chk(bad == 0, "R3 no early entry", bad, 0);
        acc_done = 1'b1;
        wait_pall(k);
        chk(k == 66, "R3 restart on acc_done", k, 66);
        leave_sr();
        tmo_code = 2'b00;

        // R7 / R8 / R9 sweep: memory type x exit delay
        for (int mk = 0; mk < 4; mk++) begin
            for (int dl = 0; dl < 4; dl++) begin
                mem_kind = 2'(mk); exit_dly = 8'(dl);
                m = (mk == 0) ? 5 : (mk == 1) ? 9 : 3;
                start_idle(k);
                tick();
                dev_sel = 1'b1;
                n = 1;
                bad = 0;
                for (int i = 0; i < 60; i++) begin
                    tick();
                    if (!cke) begin
                        n++;
                        if (!busy) bad++;
                    end else break;
                end
                chk(n == m + 1, "R7 residency", n, m + 1);
                chk(bad == 0, "R9 busy while cke low", bad, 0);
                chk(cmd_vld && cmd == 3'(C_SRX) && cke, "R8 exit strobe", cmd, C_SRX);
                d = 0; bad = 0;
                for (int i = 0; i < 20; i++) begin
                    tick();
                    if (busy) begin
                        d++;
                        if (cmd_vld || cmd != 3'd0) bad++;
                    end else break;
                end
                chk(d == dl, "R8 settle cycles", d, dl);
                chk(bad == 0, "R13 NOP during settle", bad, 0);
                chk(!busy && !cmd_vld, "R9 idle after exit", busy, 0);
            end
        end

        // R7 late access exits on the next cycle
        mem_kind = 2'b10; exit_dly = 8'd0;
        start_idle(k);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (cke) bad++;
        end
        chk(bad == 0, "R6 cke held low", bad, 0);
        dev_sel = 1'b1;
        tick();
        chk(cmd_vld && cmd == 3'(C_SRX), "R7 late exit", cmd, C_SRX);
        leave_sr();

        // R5 access during precharge-all
        start_idle(k);
        dev_sel = 1'b1;
        tick();
        chk(cmd_vld && cmd == 3'(C_AREF) && cke, "R5 AREF substitution", cmd, C_AREF);
        tick();
        chk(!busy && !cmd_vld && cke, "R5 back to idle", busy, 0);

        // R12 field changes before initialisation
        emr_fields = 7'h11; tick(); emr_fields = 7'h33; tick();
        start_idle(k);
        tick();
        chk(cmd_vld && cmd == 3'(C_SREF), "R12 no write before init", cmd, C_SREF);
        leave_sr();
        init_done = 1'b1; tick();

        // R10 dedicated bus: write inside the entry sequence
        emr_fields = 7'h2A;
        start_idle(k);
        tick();
        chk(cmd_vld && cmd == 3'(C_LEMR), "R10 LOAD_EMR in entry", cmd, C_LEMR);
        chk(emr_data == 7'h2A, "R10 written value", emr_data, 7'h2A);
        tick();
        chk(cmd_vld && cmd == 3'(C_SREF), "R10 SREF after write", cmd, C_SREF);
        leave_sr();
        start_idle(k);
        tick();
        chk(cmd_vld && cmd == 3'(C_SREF), "R10 no repeat write", cmd, C_SREF);
        leave_sr();

        // R5 with write: access during PRE still becomes AREF after LOAD_EMR
        emr_fields = 7'h0C;
        start_idle(k);
        dev_sel = 1'b1;
        tick();
        chk(cmd_vld && cmd == 3'(C_LEMR), "R10 write before AREF", cmd, C_LEMR);
        tick();
        chk(cmd_vld && cmd == 3'(C_AREF), "R5 AREF after write", cmd, C_AREF);
        tick();

        // R11 shared bus: no write in entry, write in a refresh slot
        emr_shared = 1'b1; emr_fields = 7'h15;
        start_idle(k);
        tick();
        chk(cmd_vld && cmd == 3'(C_SREF), "R11 entry skips write", cmd, C_SREF);
        leave_sr();
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            tick();
            if (cmd_vld) bad++;
        end
        chk(bad == 0, "R11 waits for refresh slot", bad, 0);
        ref_slot = 1'b1;
        tick();
        ref_slot = 1'b0;
        chk(cmd_vld && cmd == 3'(C_LEMR) && emr_data == 7'h15, "R11 write in slot", cmd, C_LEMR);
        tick();
        chk(!busy && !cmd_vld, "R11 idle after write", busy, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule